// File: doc/BRIEF.md
# Periodic Interrupt Rate Divider

This block derives a periodic interrupt event and a square-wave output from a 32.768 kHz time base. The base arrives as a one-cycle tick enable in the system clock domain. Each tick advances a free-running 16-bit count. A 4-bit rate code picks a power-of-two period, and an event fires on every tick that brings the count to an exact multiple of that period. The free-running count sets where events fall, so a software change of rate never produces a short or extra interval. The first event at the new rate lands on the next boundary of the new period.

Each event has two effects. It can raise a one-cycle strobe that sets two flag bits in a status register held elsewhere. It can also toggle a square-wave pin. Two separate enables gate these effects. The divider is idle when the rate code is zero, or when both enables are low.

Top module: `rate_divider_top`

## Requirements
- R1: A rate code of 0 produces no events. `flagSet` stays 0 and `squareOut` holds its value.
- R2: Rate codes 1 and 2 give periods of 128 and 256 ticks, the same as codes 8 and 9.
- R3: A rate code n from 3 to 15 gives a period of 2^(n-1) ticks. For example, code 3 gives 4 ticks, code 6 gives 32 ticks and code 15 gives 16384 ticks.
- R4: When `periodicEn` and `squareEn` are both low, no event has any effect on the outputs.
- R5: Events fall on ticks where the tick count since reset is an exact multiple of the period. That count includes ticks taken while the divider was idle. After a rate change, the first event falls on the next multiple of the new period, with no event in between.
- R6: An event with `periodicEn` high drives `flagSet` to 8'hC0 for exactly one cycle, the cycle after the tick. Bit 7 is the any-interrupt flag and bit 6 is the periodic flag. At all other times `flagSet` is 8'h00.
- R7: An event with `squareEn` high toggles `squareOut`. While `squareEn` is low, `squareOut` holds its value.
- R8: A synchronous reset clears the tick count, drives `flagSet` to 0 and drives `squareOut` to 0.
- R9: The count advances only on cycles with `tickEn` high. No event follows a cycle without a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tickEn | input | 1 | One-cycle enable at the 32.768 kHz time-base rate |
| rateSel | input | 4 | Rate code; 0 disables the divider |
| periodicEn | input | 1 | Lets events set the status flags |
| squareEn | input | 1 | Lets events toggle the square-wave output |
| flagSet | output | 8 | One-cycle set mask for the status register (bits 7 and 6) |
| squareOut | output | 1 | Square-wave output, toggled on each enabled event |

## Verification
The assertions check on every cycle the properties that hold regardless of the rate:
- `flagSet` only ever carries 8'h00 or 8'hC0.
- A flag strobe never lasts two cycles.
- A strobe always follows a tick.
- The outputs stay quiet and `squareOut` holds when the code is zero, when both enables are low, or when `squareEn` is low.

Only the bench scenarios can show the behaviour that needs a count over time:
- the exact period for each code, including the remapped low codes and the longest period;
- the alignment of events to multiples of the free-running count;
- the position of the first event after a rate change.

// File: rtl/rate_div_pkg.sv
package rate_div_pkg;
  parameter int unsigned CNT_W  = 16;
  parameter int unsigned RATE_W = 4;
  parameter int unsigned FLAG_W = 8;
  localparam int unsigned REMAP_LIMIT  = 2;
  localparam int unsigned REMAP_OFFSET = 7;
  localparam int unsigned ANY_BIT      = 7;
  localparam int unsigned PER_BIT      = 6;

  typedef struct packed {
    logic             run;
    logic             flagGate;
    logic             waveGate;
    logic [CNT_W-1:0] mask;
  } divCtrl_t;
endpackage

// File: rtl/rate_div_ctrl.sv
module rate_div_ctrl
  import rate_div_pkg::*;
(
  input  logic [RATE_W-1:0] rateSel,
  input  logic              periodicEn,
  input  logic              squareEn,
  output divCtrl_t          ctrl
);
  localparam int unsigned SHIFT_W = $clog2(CNT_W) + 1;

  logic [RATE_W:0]  effCode;
  logic [SHIFT_W-1:0] shiftAmt;

  always_comb begin
    if (rateSel != '0 && rateSel <= RATE_W'(REMAP_LIMIT))
      effCode = {1'b0, rateSel} + (RATE_W+1)'(REMAP_OFFSET);
    else
      effCode = {1'b0, rateSel};
    shiftAmt = (effCode == '0) ? '0 : SHIFT_W'(effCode - 1'b1);
  end

  always_comb begin
    ctrl.run      = (rateSel != '0) && (periodicEn || squareEn);
    ctrl.flagGate = periodicEn;
    ctrl.waveGate = squareEn;
    ctrl.mask     = (CNT_W'(1) << shiftAmt) - CNT_W'(1);
  end
endmodule

// File: rtl/rate_div_datapath.sv
module rate_div_datapath
  import rate_div_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tickEn,
  input  divCtrl_t          ctrl,
  output logic [FLAG_W-1:0] flagSet,
  output logic              squareOut
);
  logic [CNT_W-1:0] tickCount;
  logic [CNT_W-1:0] countNext;
  logic             onBoundary;
  logic             fire;
  logic             flagPulse;

  assign countNext  = tickCount + CNT_W'(1);
  assign onBoundary = (countNext & ctrl.mask) == '0;
  assign fire       = tickEn && ctrl.run && onBoundary;

  always_ff @(posedge clk) begin
    if (rst) begin
      tickCount <= '0;
      flagPulse <= 1'b0;
      squareOut <= 1'b0;
    end else begin
      if (tickEn) tickCount <= countNext;
      flagPulse <= fire && ctrl.flagGate;
      if (fire && ctrl.waveGate) squareOut <= ~squareOut;
    end
  end

  always_comb begin
    flagSet          = '0;
    flagSet[ANY_BIT] = flagPulse;
    flagSet[PER_BIT] = flagPulse;
  end
endmodule

// File: rtl/rate_divider_top.sv
module rate_divider_top
  import rate_div_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tickEn,
  input  logic [RATE_W-1:0] rateSel,
  input  logic              periodicEn,
  input  logic              squareEn,
  output logic [FLAG_W-1:0] flagSet,
  output logic              squareOut
);
  divCtrl_t ctrl;

  rate_div_ctrl u_ctrl (
    .rateSel    (rateSel),
    .periodicEn (periodicEn),
    .squareEn   (squareEn),
    .ctrl       (ctrl)
  );

  rate_div_datapath u_dp (
    .clk       (clk),
    .rst       (rst),
    .tickEn    (tickEn),
    .ctrl      (ctrl),
    .flagSet   (flagSet),
    .squareOut (squareOut)
  );
endmodule

// File: rtl/rate_divider_checker.sv
module rate_divider_checker
  import rate_div_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              tickEn,
  input logic [RATE_W-1:0] rateSel,
  input logic              periodicEn,
  input logic              squareEn,
  input logic [FLAG_W-1:0] flagSet,
  input logic              squareOut
);
  a_r6_flag_shape: assert property (@(posedge clk) disable iff (rst)
    (flagSet == 8'h00) || (flagSet == 8'hC0));

  a_r6_single_cycle: assert property (@(posedge clk) disable iff (rst)
    flagSet[7] |=> !flagSet[7]);

  a_r1_zero_quiet: assert property (@(posedge clk) disable iff (rst)
    (rateSel == '0) |=> (flagSet == '0) && $stable(squareOut));

  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!periodicEn && !squareEn) |=> (flagSet == '0) && $stable(squareOut));

  a_r7_wave_hold: assert property (@(posedge clk) disable iff (rst)
    !squareEn |=> $stable(squareOut));

  a_r9_needs_tick: assert property (@(posedge clk) disable iff (rst)
    !tickEn |=> (flagSet == '0));

  a_r6_needs_enable: assert property (@(posedge clk) disable iff (rst)
    !periodicEn |=> (flagSet == '0));
endmodule

bind rate_divider_top rate_divider_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .tickEn     (tickEn),
  .rateSel    (rateSel),
  .periodicEn (periodicEn),
  .squareEn   (squareEn),
  .flagSet    (flagSet),
  .squareOut  (squareOut)
);

// File: tb/sim_rate_divider_top.sv
module sim_rate_divider_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tickEn = 1'b0;
  logic [3:0] rateSel = 4'd0;
  logic       periodicEn = 1'b0;
  logic       squareEn = 1'b0;
  logic [7:0] flagSet;
  logic       squareOut;

  int errors = 0;
  int checks = 0;
  int flagCnt = 0;
  int togCnt = 0;
  logic sqPrev = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rate_divider_top u0 (
    .clk(clk), .rst(rst), .tickEn(tickEn), .rateSel(rateSel),
    .periodicEn(periodicEn), .squareEn(squareEn),
    .flagSet(flagSet), .squareOut(squareOut)
  );

  typedef struct packed {
    logic [3:0]  rate;
    logic        pie;
    logic        sqe;
    logic [31:0] ticks;
    logic [31:0] expFlags;
    logic [31:0] expToggles;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{4'd0,  1'b1, 1'b1, 32'd300,   32'd0,  32'd0},  // R1
    '{4'd3,  1'b1, 1'b0, 32'd40,    32'd10, 32'd0},  // R3 period 4
    '{4'd1,  1'b1, 1'b0, 32'd300,   32'd2,  32'd0},  // R2 period 128
    '{4'd2,  1'b1, 1'b1, 32'd600,   32'd2,  32'd2},  // R2 period 256
    '{4'd6,  1'b0, 1'b1, 32'd100,   32'd0,  32'd3},  // R7 period 32
    '{4'd6,  1'b0, 1'b0, 32'd100,   32'd0,  32'd0},  // R4
    '{4'd8,  1'b1, 1'b1, 32'd128,   32'd1,  32'd1},  // R2 equivalence
    '{4'd15, 1'b1, 1'b0, 32'd16384, 32'd1,  32'd0},  // R3 longest
    '{4'd4,  1'b1, 1'b1, 32'd7,     32'd0,  32'd0}   // R5 short of boundary
  };

  always @(negedge clk) begin
    if (!rst) begin
      if (flagSet == 8'hC0) flagCnt++;
      if (squareOut != sqPrev) togCnt++;
      sqPrev = squareOut;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    tickEn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    flagCnt = 0;
    togCnt = 0;
    sqPrev = 1'b0;
    rst = 1'b0;
  endtask

  // one tick followed by two idle cycles; ev = strobe seen the cycle after
  task automatic doTick(output bit ev);
    @(negedge clk);
    tickEn = 1'b1;
    @(negedge clk);
    tickEn = 1'b0;
    ev = (flagSet == 8'hC0);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit ev;
    int firstAt;
    int extra;
    doReset();
    // R8 reset state
    chk(flagSet == 8'h00, "R8 reset flagSet", flagSet, 0);
    chk(squareOut == 1'b0, "R8 reset squareOut", squareOut, 0);

    for (int i = 0; i < NV; i++) begin
      doReset();
      rateSel = VECS[i].rate;
      periodicEn = VECS[i].pie;
      squareEn = VECS[i].sqe;
      @(negedge clk);
      tickEn = 1'b1;
      repeat (int'(VECS[i].ticks)) @(negedge clk);
      tickEn = 1'b0;
      repeat (2) @(negedge clk);
      chk(flagCnt == int'(VECS[i].expFlags), $sformatf("R3/R2/R6 vec%0d flags", i),
          flagCnt, int'(VECS[i].expFlags));
      chk(togCnt == int'(VECS[i].expToggles), $sformatf("R7/R4/R1 vec%0d toggles", i),
          togCnt, int'(VECS[i].expToggles));
    end

    // R5 alignment to the free-running count, with gaps between ticks (R9)
    doReset();
    periodicEn = 1'b1;
    rateSel = 4'd0;
    extra = 0;
    for (int t = 1; t <= 5; t++) begin
      doTick(ev);
      if (ev) extra++;
    end
    chk(extra == 0, "R1 idle ticks with code 0", extra, 0);
    rateSel = 4'd3;
    firstAt = 0;
    for (int t = 6; t <= 8; t++) begin
      doTick(ev);
      if (ev && firstAt == 0) firstAt = t;
    end
    chk(firstAt == 8, "R5 first event on multiple of 4", firstAt, 8);
    rateSel = 4'd5;
    firstAt = 0;
    for (int t = 9; t <= 16; t++) begin
      doTick(ev);
      if (ev && firstAt == 0) firstAt = t;
    end
    chk(firstAt == 16, "R5 rate change waits for multiple of 16", firstAt, 16);
    // R9 long idle gap without ticks produces nothing
    flagCnt = 0;
    repeat (50) @(negedge clk);
    chk(flagCnt == 0, "R9 no event without ticks", flagCnt, 0);

    // R8 reset clears square output mid-run
    doReset();
    rateSel = 4'd3;
    squareEn = 1'b1;
    periodicEn = 1'b0;
    for (int t = 1; t <= 4; t++) doTick(ev);
    chk(squareOut == 1'b1, "R7 square toggled after one event", squareOut, 1);
    squareEn = 1'b0;
    for (int t = 5; t <= 8; t++) doTick(ev);
    chk(squareOut == 1'b1, "R7 square holds with enable low", squareOut, 1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(squareOut == 1'b0, "R8 reset clears square", squareOut, 0);
    rst = 1'b0;
    // R8 count cleared: period 4 event lands on 4th tick after reset
    periodicEn = 1'b1;
    firstAt = 0;
    for (int t = 1; t <= 4; t++) begin
      doTick(ev);
      if (ev && firstAt == 0) firstAt = t;
    end
    chk(firstAt == 4, "R8 count restarts from zero", firstAt, 4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule